// File: doc/BRIEF.md
# Memory-Card Command Issue and Response Capture

This unit sits in a memory-card host controller between the register interface and the card model. It holds the command index, the 32-bit argument and the command configuration. It decides in which cycle a command goes to the card. A command issues when the configuration is written while the card clock runs. If the clock is off at that write, the command is held pending and issues on the next clock-start write.

When a command issues, the card model answers in the same cycle with a byte array and a length. The unit compares that length against the minimum for the configured response type. A short response sets a timeout status bit and clears the response store. A long enough response is packed into nine 16-bit words, and the CPU reads these one at a time through the response port. Each issue raises a one-cycle end-of-command event. A valid response with data enabled also raises a one-cycle pulse that hands the transfer to the data FIFO engine.

All register traffic uses one write port. The select codes are 0 for the command index, 1 for the argument high half, 2 for the argument low half, 3 for the configuration, and 4 for clock control, where bit 1 starts the clock and bit 0 stops it.

Top module: `cmdRespUnit`

## Requirements
- R1: A command-index write (select 0) keeps data bits 5:0. `cmdReadBack` returns that index with bit 6 forced to 1, so it reads 0x40 after reset.
- R2: A select-1 write replaces `argOut[31:16]` and a select-2 write replaces `argOut[15:0]`. Neither write changes the other half.
- R3: A configuration write (select 3) stores `wrData & 0x3dff` on `cfgOut`. If data bit 10 (stop-transfer) is clear and the clock is enabled, `cmdIssue` is high during that same write cycle.
- R4: A configuration write always marks a command pending. A later clock-start write (select 4, bit 1 set, bit 0 clear) drives `cmdIssue` high in its own cycle only if a command is pending and stored configuration bit 10 is clear. No issue happens with the clock stopped.
- R5: An issue clears status bits 1 and 13, keeps status bit 8, and raises `endCmdEvt` for exactly the next cycle.
- R6: Response type is configuration bits 1:0. Type 0 needs 0 bytes, types 1 and 3 need 4 bytes, and type 2 needs 16 bytes. If `cardRespLen` is below the minimum, the issue sets status bit 1, reads back all nine words as zero, and gives no `dataStart`.
- R7: If the response is long enough, the issue sets status bit 13. `dataStart` is high for the next cycle exactly when configuration bit 2 (data enable) is set.
- R8: After a valid response, word k is {byte 2k-1, byte 2k}, with the high byte in bits 15:8. Byte j is `cardRespData[8j+7:8j]` when j < `cardRespLen`, and zero otherwise (including byte -1 and byte 16).
- R9: `respWord` shows the word at the read pointer. Each cycle with `respRd` high advances the pointer, and after nine words `respWord` reads zero. Every issue resets the pointer to word 0.
- R10: A clock-stop write (bit 0) clears status bit 8. A clock-start write sets it. A clock-stop write or a configuration write raises `xferAbort` for the next cycle.
- R11: An issue clears the pending flag, so a repeated clock-start write does not issue again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Write target select (0..4) |
| wrData | input | 16 | Write data |
| respRd | input | 1 | Response port read strobe |
| cardRespLen | input | 5 | Card response length in bytes (0..16) |
| cardRespData | input | 128 | Card response bytes, byte j at bits 8j+7:8j |
| cmdReadBack | output | 7 | Command index with bit 6 set |
| argOut | output | 32 | Stored argument |
| cfgOut | output | 14 | Stored configuration |
| statusOut | output | 14 | Status: bit 1 timeout, bit 8 clock on, bit 13 response done |
| cmdIssue | output | 1 | Command goes to the card this cycle |
| respWord | output | 16 | Response word at the read pointer |
| endCmdEvt | output | 1 | One-cycle end-of-command event |
| dataStart | output | 1 | One-cycle data phase hand-off |
| xferAbort | output | 1 | One-cycle abort of an active transfer |

## Verification
`cmdIssue` and `respWord` are combinational. They are due in the same cycle as the write or read strobe, and the bench samples them 1 ns after it drives the strobe. Status, stored registers, the response words and the `endCmdEvt`, `dataStart` and `xferAbort` pulses change at the first rising edge after the strobe. They are compared at the next falling edge and 5 ns after each rising edge. A behavioural model steps once per rising edge on the same inputs and is compared at both sample points. Directed checks with fixed expected values cover the pending-issue path, the timeout path and read-pointer restart.

// File: rtl/cmdRespPkg.sv
`timescale 1ns/1ps
package cmdRespPkg;
  localparam int RESP_WORDS = 9;
  localparam int RESP_W     = 16;
  localparam int CARD_BYTES = 2 * (RESP_WORDS - 1);
  localparam int LEN_W      = $clog2(CARD_BYTES + 1);
  localparam int PTR_W      = $clog2(RESP_WORDS + 1);
  localparam int CMD_W      = 6;
  localparam int CFG_W      = 14;
  localparam int WR_W       = 16;
  localparam int ARG_W      = 2 * WR_W;
  localparam int STAT_W     = 14;
  localparam logic [CFG_W-1:0] CFG_MASK = 14'h3dff;

  localparam int CFG_DATA_EN = 2;
  localparam int CFG_STOP    = 10;
  localparam int ST_TOUT     = 1;
  localparam int ST_CLKON    = 8;
  localparam int ST_RESP     = 13;

  typedef enum logic [2:0] {
    SEL_CMD   = 3'd0,
    SEL_ARGHI = 3'd1,
    SEL_ARGLO = 3'd2,
    SEL_CFG   = 3'd3,
    SEL_CLOCK = 3'd4
  } wrSel_e;

  typedef struct packed {
    logic load;   // capture packed response, restart pointer
    logic clear;  // zero response store, restart pointer
    logic pop;    // advance read pointer
  } respStrobe_t;

  function automatic logic [LEN_W-1:0] minRespLen(input logic [1:0] respType);
    case (respType)
      2'd0:    minRespLen = '0;
      2'd2:    minRespLen = LEN_W'(CARD_BYTES);
      default: minRespLen = LEN_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/cmdRespCtrl.sv
`timescale 1ns/1ps
module cmdRespCtrl
  import cmdRespPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrSel,
  input  logic [WR_W-1:0]    wrData,
  input  logic               respRd,
  input  logic [LEN_W-1:0]   cardRespLen,
  output logic [CMD_W:0]     cmdReadBack,
  output logic [ARG_W-1:0]   argOut,
  output logic [CFG_W-1:0]   cfgOut,
  output logic [STAT_W-1:0]  statusOut,
  output logic               cmdIssue,
  output logic               endCmdEvt,
  output logic               dataStart,
  output logic               xferAbort,
  output respStrobe_t        strb
);
  logic [CMD_W-1:0] cmdQ;
  logic [ARG_W-1:0] argQ;
  logic [CFG_W-1:0] cfgQ;
  logic clkOnQ, pendQ, toutQ, respQ;

  logic wrCmd, wrHi, wrLo, wrCfg, wrClk, clkStart, clkStop, shortResp;
  logic [CFG_W-1:0] effCfg;

  always_comb begin
    wrCmd    = wrEn && (wrSel == SEL_CMD);
    wrHi     = wrEn && (wrSel == SEL_ARGHI);
    wrLo     = wrEn && (wrSel == SEL_ARGLO);
    wrCfg    = wrEn && (wrSel == SEL_CFG);
    wrClk    = wrEn && (wrSel == SEL_CLOCK);
    clkStop  = wrClk && wrData[0];
    clkStart = wrClk && wrData[1] && !wrData[0];
    // a config write decides with its own new value
    effCfg   = wrCfg ? (wrData[CFG_W-1:0] & CFG_MASK) : cfgQ;
    cmdIssue = (wrCfg && !wrData[CFG_STOP] && clkOnQ) ||
               (clkStart && pendQ && !cfgQ[CFG_STOP]);
    shortResp = cardRespLen < minRespLen(effCfg[1:0]);
    strb.load  = cmdIssue && !shortResp;
    strb.clear = cmdIssue && shortResp;
    strb.pop   = respRd && !cmdIssue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ      <= '0;
      argQ      <= '0;
      cfgQ      <= '0;
      clkOnQ    <= 1'b0;
      pendQ     <= 1'b0;
      toutQ     <= 1'b0;
      respQ     <= 1'b0;
      endCmdEvt <= 1'b0;
      dataStart <= 1'b0;
      xferAbort <= 1'b0;
    end else begin
      if (wrCmd) cmdQ <= wrData[CMD_W-1:0];
      if (wrHi)  argQ <= {wrData, argQ[WR_W-1:0]};
      if (wrLo)  argQ <= {argQ[ARG_W-1:WR_W], wrData};
      if (wrCfg) cfgQ <= effCfg;
      if (clkStop)       clkOnQ <= 1'b0;
      else if (clkStart) clkOnQ <= 1'b1;
      if (cmdIssue)   pendQ <= 1'b0;
      else if (wrCfg) pendQ <= 1'b1;
      if (cmdIssue) begin
        toutQ <= shortResp;
        respQ <= !shortResp;
      end
      endCmdEvt <= cmdIssue;
      dataStart <= cmdIssue && !shortResp && effCfg[CFG_DATA_EN];
      xferAbort <= wrCfg || clkStop;
    end
  end

  always_comb begin
    statusOut           = '0;
    statusOut[ST_TOUT]  = toutQ;
    statusOut[ST_CLKON] = clkOnQ;
    statusOut[ST_RESP]  = respQ;
  end

  assign cmdReadBack = {1'b1, cmdQ};
  assign argOut      = argQ;
  assign cfgOut      = cfgQ;
endmodule

// File: rtl/cmdRespData.sv
`timescale 1ns/1ps
module cmdRespData
  import cmdRespPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  respStrobe_t             strb,
  input  logic [LEN_W-1:0]        respLen,
  input  logic [CARD_BYTES*8-1:0] respData,
  output logic [RESP_W-1:0]       respWord
);
  logic [RESP_WORDS-1:0][RESP_W-1:0] packedW;
  logic [RESP_WORDS-1:0][RESP_W-1:0] wordQ;
  logic [PTR_W-1:0]                  ptrQ;

  for (genvar k = 0; k < RESP_WORDS; k++) begin : g_word
    localparam int LO = 2 * k;
    localparam int HI = 2 * k - 1;
    logic [7:0] loByte, hiByte;
    if (LO < CARD_BYTES) begin : g_lo
      assign loByte = (int'(respLen) > LO) ? respData[8*LO +: 8] : 8'h00;
    end else begin : g_lo0
      assign loByte = 8'h00;
    end
    if (k > 0 && HI < CARD_BYTES) begin : g_hi
      assign hiByte = (int'(respLen) > HI) ? respData[8*HI +: 8] : 8'h00;
    end else begin : g_hi0
      assign hiByte = 8'h00;
    end
    assign packedW[k] = {hiByte, loByte};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
      ptrQ  <= '0;
    end else if (strb.load) begin
      wordQ <= packedW;
      ptrQ  <= '0;
    end else if (strb.clear) begin
      wordQ <= '0;
      ptrQ  <= '0;
    end else if (strb.pop && (ptrQ < PTR_W'(RESP_WORDS))) begin
      ptrQ <= ptrQ + PTR_W'(1);
    end
  end

  assign respWord = (ptrQ < PTR_W'(RESP_WORDS)) ? wordQ[ptrQ] : '0;
endmodule

// File: rtl/cmdRespUnit.sv
`timescale 1ns/1ps
module cmdRespUnit
  import cmdRespPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [2:0]              wrSel,
  input  logic [WR_W-1:0]         wrData,
  input  logic                    respRd,
  input  logic [LEN_W-1:0]        cardRespLen,
  input  logic [CARD_BYTES*8-1:0] cardRespData,
  output logic [CMD_W:0]          cmdReadBack,
  output logic [ARG_W-1:0]        argOut,
  output logic [CFG_W-1:0]        cfgOut,
  output logic [STAT_W-1:0]       statusOut,
  output logic                    cmdIssue,
  output logic [RESP_W-1:0]       respWord,
  output logic                    endCmdEvt,
  output logic                    dataStart,
  output logic                    xferAbort
);
  respStrobe_t strb;

  cmdRespCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .respRd(respRd), .cardRespLen(cardRespLen),
    .cmdReadBack(cmdReadBack), .argOut(argOut), .cfgOut(cfgOut),
    .statusOut(statusOut), .cmdIssue(cmdIssue), .endCmdEvt(endCmdEvt),
    .dataStart(dataStart), .xferAbort(xferAbort), .strb(strb)
  );

  cmdRespData u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .respLen(cardRespLen),
    .respData(cardRespData), .respWord(respWord)
  );
endmodule

// File: rtl/cmdRespUnit_chk.sv
`timescale 1ns/1ps
module cmdRespUnit_chk
  import cmdRespPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [2:0]          wrSel,
  input logic [WR_W-1:0]     wrData,
  input logic [CMD_W:0]      cmdReadBack,
  input logic [STAT_W-1:0]   statusOut,
  input logic                cmdIssue,
  input logic [RESP_W-1:0]   respWord,
  input logic                endCmdEvt,
  input logic                dataStart,
  input logic                xferAbort
);
  p_readback_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdReadBack[CMD_W]);

  p_issue_needs_clock_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdIssue |-> (statusOut[ST_CLKON] || (wrEn && wrSel == SEL_CLOCK && wrData[1])));

  p_issue_event_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdIssue |=> endCmdEvt);

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdIssue |=> (statusOut[ST_TOUT] != statusOut[ST_RESP]));

  p_timeout_no_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (endCmdEvt && statusOut[ST_TOUT]) |-> (!dataStart && respWord == '0));

  p_data_after_resp_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataStart |-> (statusOut[ST_RESP] && endCmdEvt));

  p_clock_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_CLOCK && wrData[0]) |=> (!statusOut[ST_CLKON] && xferAbort));
endmodule

bind cmdRespUnit cmdRespUnit_chk u_chk (.*);

// File: tb/cmdRespUnit_test.sv
`timescale 1ns/1ps
module cmdRespUnit_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrSel = '0;
  logic [15:0]  wrData = '0;
  logic         respRd = 1'b0;
  logic [4:0]   cardRespLen = '0;
  logic [127:0] cardRespData = '0;
  logic [6:0]   cmdReadBack;
  logic [31:0]  argOut;
  logic [13:0]  cfgOut, statusOut;
  logic         cmdIssue, endCmdEvt, dataStart, xferAbort;
  logic [15:0]  respWord;

  int nChk = 0, nBad = 0;

  cmdRespUnit uut (.*);

  always #10 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int mCmd, mCfg, mClk, mPend, mTout, mResp, mPtr, mEnd, mDs, mAb;
  logic [31:0] mArg;
  int mWords[9];

  function automatic int reqOf(int t);
    return (t == 0) ? 0 : ((t == 2) ? 16 : 4);
  endfunction

  function automatic int byteAt(int j);
    if (j < 0 || j >= 16 || j >= int'(cardRespLen)) return 0;
    return int'(cardRespData[8*j +: 8]);
  endfunction

  function automatic int mIssueNow();
    if (wrEn && wrSel == 3'd3 && !wrData[10] && mClk == 1) return 1;
    if (wrEn && wrSel == 3'd4 && wrData[1] && !wrData[0] && mPend == 1 && ((mCfg >> 10) & 1) == 0) return 1;
    return 0;
  endfunction

  function automatic int mStatus();
    return (mClk << 8) | (mTout << 1) | (mResp << 13);
  endfunction

  function automatic int mWordNow();
    return (mPtr < 9) ? mWords[mPtr] : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCmd = 0; mArg = '0; mCfg = 0; mClk = 0; mPend = 0; mTout = 0; mResp = 0;
      mPtr = 0; mEnd = 0; mDs = 0; mAb = 0;
      foreach (mWords[i]) mWords[i] = 0;
    end else begin
      int iss, eff;
      iss = mIssueNow();
      eff = (wrEn && wrSel == 3'd3) ? (int'(wrData) & 'h3dff) : mCfg;
      mEnd = 0; mDs = 0; mAb = 0;
      if (wrEn) begin
        case (wrSel)
          3'd0: mCmd = int'(wrData) & 63;
          3'd1: mArg = {wrData, mArg[15:0]};
          3'd2: mArg = {mArg[31:16], wrData};
          3'd3: begin mCfg = eff; mPend = 1; mAb = 1; end
          3'd4: if (wrData[0]) begin mClk = 0; mAb = 1; end
                else if (wrData[1]) mClk = 1;
          default: ;
        endcase
      end
      if (iss == 1) begin
        mPend = 0; mEnd = 1; mPtr = 0;
        if (int'(cardRespLen) < reqOf(eff & 3)) begin
          mTout = 1; mResp = 0;
          foreach (mWords[i]) mWords[i] = 0;
        end else begin
          mTout = 0; mResp = 1;
          foreach (mWords[i]) mWords[i] = byteAt(2*i) | (byteAt(2*i - 1) << 8);
          mDs = (eff >> 2) & 1;
        end
      end else if (respRd && mPtr < 9) begin
        mPtr++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpAll();
    chk("R1 cmdReadBack", int'(cmdReadBack), 'h40 | mCmd);
    chk("R2 argOut", int'(argOut), int'(mArg));
    chk("R3 cfgOut", int'(cfgOut), mCfg);
    chk("R4 cmdIssue", int'(cmdIssue), mIssueNow());
    chk("R5 statusOut", int'(statusOut), mStatus());
    chk("R5 endCmdEvt", int'(endCmdEvt), mEnd);
    chk("R7 dataStart", int'(dataStart), mDs);
    chk("R8 respWord", int'(respWord), mWordNow());
    chk("R10 xferAbort", int'(xferAbort), mAb);
  endtask

  always @(posedge clk) begin #5; if (rstN) cmpAll(); end
  always @(negedge clk) begin #5; if (rstN) cmpAll(); end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [2:0] sel, logic [15:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrIss(logic [2:0] sel, logic [15:0] d, int expIss, string tag);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    #1 chk(tag, int'(cmdIssue), expIss);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int exp, string tag);
    respRd = 1'b1;
    #1 chk(tag, int'(respWord), exp);
    @(negedge clk);
    respRd = 1'b0;
  endtask

  task automatic setCard(int len, int base);
    cardRespLen = 5'(len);
    for (int j = 0; j < 16; j++) cardRespData[8*j +: 8] = 8'(base + j);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    chk("R1 reset readback", int'(cmdReadBack), 'h40);
    chk("R5 reset status", int'(statusOut), 0);
    chk("R9 reset respWord", int'(respWord), 0);

    wr(3'd0, 16'h00FF);
    chk("R1 index masked", int'(cmdReadBack), 'h7F);
    wr(3'd1, 16'h1234);
    wr(3'd2, 16'hABCD);
    chk("R2 both halves", int'(argOut), 'h1234ABCD);
    wr(3'd1, 16'h5555);
    chk("R2 high only", int'(argOut), 'h5555ABCD);

    // config with stop-transfer set while clock off
    wrIss(3'd3, 16'hFFFF, 0, "R4 no issue clock off");
    chk("R3 cfg mask", int'(cfgOut), 'h3dff);
    chk("R10 abort on cfg", int'(xferAbort), 1);
    wrIss(3'd4, 16'h0002, 0, "R4 stop bit blocks");
    chk("R10 clock on", int'(statusOut), 'h0100);
    wr(3'd4, 16'h0001);
    chk("R10 clock off", int'(statusOut), 'h0000);
    chk("R10 abort on stop", int'(xferAbort), 1);

    // pending command issued by clock start
    setCard(4, 'h11);
    wrIss(3'd3, 16'h0005, 0, "R4 pend clock off");
    wrIss(3'd4, 16'h0002, 1, "R4 issue on start");
    chk("R5 end event", int'(endCmdEvt), 1);
    chk("R7 status resp", int'(statusOut), 'h2100);
    chk("R7 data start", int'(dataStart), 1);
    @(negedge clk);
    chk("R5 event one cycle", int'(endCmdEvt), 0);
    rd('h0011, "R8 word0");
    rd('h1213, "R8 word1");
    rd('h1400, "R8 word2");
    for (int k = 3; k < 9; k++) rd(0, "R8 upper zero");
    rd(0, "R9 past end");
    wrIss(3'd4, 16'h0002, 0, "R11 no reissue");

    // immediate issue, short response
    setCard(15, 'h30);
    wrIss(3'd3, 16'h0002, 1, "R3 immediate issue");
    chk("R6 timeout status", int'(statusOut), 'h0102);
    chk("R6 no data", int'(dataStart), 0);
    rd(0, "R6 cleared word");

    // full 16-byte response
    setCard(16, 'hA0);
    wrIss(3'd3, 16'h0006, 1, "R3 issue type2");
    chk("R7 status type2", int'(statusOut), 'h2100);
    for (int k = 0; k < 9; k++) begin
      int e;
      e = ((2*k < 16) ? ('hA0 + 2*k) : 0) | ((k > 0) ? (('hA0 + 2*k - 1) << 8) : 0);
      if (k < 3) rd(e, "R8 long word");
    end
    setCard(4, 'h77);
    wrIss(3'd3, 16'h0003, 1, "R3 issue type3");
    chk("R7 no data when disabled", int'(dataStart), 0);
    rd('h0077, "R9 pointer restart");
    rd('h7879, "R9 next word");

    setCard(3, 'h50);
    wrIss(3'd3, 16'h0001, 1, "R3 issue type1");
    chk("R6 short type1", int'(statusOut), 'h0102);
    wrIss(3'd3, 16'h0401, 0, "R4 stop set clock on");
    wrIss(3'd4, 16'h0002, 0, "R4 stop held");

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      wrEn   = ($urandom_range(2, 0) != 0);
      wrSel  = 3'($urandom_range(4, 0));
      wrData = 16'($urandom) & ((($urandom_range(3, 0)) == 0) ? 16'hFFFF : 16'hFBFF);
      respRd = $urandom_range(1, 0) == 1;
      cardRespLen  = 5'($urandom_range(16, 0));
      cardRespData = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
    end
    wrEn = 1'b0; respRd = 1'b0;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule